// File: doc/BRIEF.md
# Prescaled Stopwatch and Interval Timer

This block keeps time for a processor subsystem from one shared clock divider. A prescaler divides the system clock by `PRESCALE` (384 by default) and emits a one-cycle tick. The tick advances a free-running 12-bit elapsed-time counter, which any bus master may read and clear through a small word-addressed register port. The same tick drives a reloading interval timer. That timer takes an 8-bit period N and raises a level-3 interrupt request each time N ticks have passed.

The interval timer is a two-state machine. `IVT_IDLE` means it is stopped. `IVT_RUN` means it is counting down. The transition IDLE->RUN happens when a nonzero period is loaded. RUN->RUN (restart) happens when a new nonzero period is loaded. RUN->RUN (reload) happens when the count expires and the period is reloaded. RUN->IDLE happens when a zero period is loaded. In IDLE, any load of zero keeps it in IDLE. The interrupt request is gated by an external mask input and is held until an acknowledge pulse clears it.

The register port has two words. Word 0 is the elapsed counter. Word 1 is the period. Read data is registered.

Top module: `prescaled_timer`

## Requirements
- R1: The elapsed counter increases by exactly one every `PRESCALE` clocks and wraps from 4095 to 0.
- R2: A read of word address 0 returns the 12-bit elapsed count in bits 11:0, with bits 15:12 zero.
- R3: A write to word address 0 with either byte lane enabled (`bus_wbe` 01, 10 or 11) clears the elapsed counter to zero, whatever the write data is.
- R4: Clearing the elapsed counter also restarts the prescaler, so the first increment after a clear comes exactly `PRESCALE` clocks later.
- R5: Word address 1 holds the period N in bits 7:0.
    - A write with lane 0 enabled (`bus_wbe[0]`=1) loads N from `bus_wdata[7:0]`.
    - A write that enables only lane 1 leaves N unchanged.
    - A read returns N in bits 7:0, with the upper bits zero.
- R6: With N nonzero, the timer expires on the Nth prescaler tick after the load. When N is loaded in the cycle after a clear, this is exactly N×`PRESCALE` clocks after the clear.
- R7: After it expires, the timer reloads N and expires again every N ticks.
- R8: Loading N = 0 stops the timer, and it does not expire again.
- R9: An expiry sets `irq3_req` only when `irq_mask` is high in that cycle. A masked expiry is lost.
- R10: `irq3_req` stays high until a cycle in which `irq3_ack` is high. If an expiry falls in the same cycle as the acknowledge, the expiry wins.
- R11: `bus_rdata` is loaded on the clock edge where `bus_rd` is high, from the register state before that edge, and it holds until the next read.
- R12: After reset, the elapsed count, N, `bus_rdata` and `irq3_req` are all zero, and the timer is in `IVT_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 1 | Word select: 0 = elapsed counter, 1 = period |
| bus_wdata | input | DATA_W | Write data |
| bus_wbe | input | 2 | Byte-lane write enables; any nonzero value is a write |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| irq_mask | input | 1 | Level-3 interrupt enable |
| irq3_ack | input | 1 | Clears the pending interrupt request |
| irq3_req | output | 1 | Level-3 interrupt request |

## Verification
The bench builds the block with `PRESCALE` = 8 and all other parameters at their defaults. At this scale, a full 4096-tick wrap of the elapsed counter takes about 33 thousand cycles. Several interval periods, including a masked expiry and a periodic reload, fit in about a hundred cycles. The exact tick count still exercises the prescaler restart on clear and the Nth-tick expiry timing, which are checked to the cycle against counts derived from the requirements.

// File: rtl/prescaled_timer_pkg.sv
package prescaled_timer_pkg;
    typedef enum logic [0:0] {
        IVT_IDLE = 1'b0,
        IVT_RUN  = 1'b1
    } ivt_state_t;

    localparam logic REG_ELAPSED = 1'b0;
    localparam logic REG_PERIOD  = 1'b1;
endpackage

// File: rtl/pt_prescaler.sv
module pt_prescaler #(
    parameter int DIV = 384
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] phase_q;

    assign tick = (phase_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart || tick) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + CW'(1);
        end
    end
endmodule

// File: rtl/pt_elapsed.sv
module pt_elapsed #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         tick,
    output logic [W-1:0] value
);
    logic [W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear) begin
            count_q <= '0;
        end else if (tick) begin
            count_q <= count_q + W'(1);
        end
    end

    assign value = count_q;
endmodule

// File: rtl/pt_interval.sv
module pt_interval
    import prescaled_timer_pkg::*;
#(
    parameter int NW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [NW-1:0] load_val,
    input  logic          tick,
    input  logic          irq_mask,
    input  logic          irq_ack,
    output logic [NW-1:0] period,
    output logic          expire,
    output logic          irq,
    output ivt_state_t    state
);
    localparam logic [NW-1:0] ONE = NW'(1);

    ivt_state_t    state_q, state_d;
    logic [NW-1:0] period_q;
    logic [NW-1:0] remain_q;
    logic          irq_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IVT_IDLE: if (load && load_val != '0) state_d = IVT_RUN;
            IVT_RUN:  if (load && load_val == '0) state_d = IVT_IDLE;
            default:  state_d = IVT_IDLE;
        endcase
    end

    assign expire = (state_q == IVT_RUN) && !load && tick && (remain_q == ONE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IVT_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q <= '0;
            remain_q <= '0;
            irq_q    <= 1'b0;
        end else begin
            if (load) begin
                period_q <= load_val;
                remain_q <= load_val;
            end else if (state_q == IVT_RUN && tick) begin
                remain_q <= (remain_q == ONE) ? period_q : remain_q - ONE;
            end

            if (expire && irq_mask) irq_q <= 1'b1;
            else if (irq_ack)       irq_q <= 1'b0;
        end
    end

    assign period = period_q;
    assign irq    = irq_q;
    assign state  = state_q;
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
    import prescaled_timer_pkg::*;
#(
    parameter int PRESCALE = 384,
    parameter int SW_W     = 12,
    parameter int IVT_W    = 8,
    parameter int DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [1:0]        bus_wbe,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              irq_mask,
    input  logic              irq3_ack,
    output logic              irq3_req
);
    localparam int SW_PAD  = DATA_W - SW_W;
    localparam int IVT_PAD = DATA_W - IVT_W;

    logic             tick_w;
    logic             sw_clear;
    logic             ivt_load;
    logic [SW_W-1:0]  sw_val;
    logic [IVT_W-1:0] ivt_period;
    logic             ivt_expire;
    ivt_state_t       ivt_st;
    logic [DATA_W-1:0] rdata_q;

    assign sw_clear = (|bus_wbe) && (bus_addr == REG_ELAPSED);
    assign ivt_load = bus_wbe[0] && (bus_addr == REG_PERIOD);

    pt_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (sw_clear),
        .tick    (tick_w)
    );

    pt_elapsed #(.W(SW_W)) u_elapsed (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (sw_clear),
        .tick  (tick_w),
        .value (sw_val)
    );

    pt_interval #(.NW(IVT_W)) u_interval (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ivt_load),
        .load_val (bus_wdata[IVT_W-1:0]),
        .tick     (tick_w),
        .irq_mask (irq_mask),
        .irq_ack  (irq3_ack),
        .period   (ivt_period),
        .expire   (ivt_expire),
        .irq      (irq3_req),
        .state    (ivt_st)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            if (bus_addr == REG_ELAPSED) rdata_q <= {{SW_PAD{1'b0}}, sw_val};
            else                         rdata_q <= {{IVT_PAD{1'b0}}, ivt_period};
        end
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/prescaled_timer_chk.sv
module prescaled_timer_chk
    import prescaled_timer_pkg::*;
#(
    parameter int SW_W   = 12,
    parameter int IVT_W  = 8,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [1:0]        bus_wbe,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq_mask,
    input logic              irq3_ack,
    input logic              irq3_req,
    input logic              tick,
    input logic [SW_W-1:0]   sw_value,
    input logic              expire,
    input ivt_state_t        ivt_state
);
    logic clr;
    assign clr = (|bus_wbe) && (bus_addr == REG_ELAPSED);

    p_sw_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr) |=> sw_value == $past(sw_value) + SW_W'(1));

    p_sw_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(sw_value));

    p_read_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == REG_ELAPSED) |=> bus_rdata[DATA_W-1:SW_W] == '0);

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> sw_value == '0);

    p_zero_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wbe[0] && bus_addr == REG_PERIOD && bus_wdata[IVT_W-1:0] == '0)
        |=> ivt_state == IVT_IDLE);

    p_no_expire_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ivt_state == IVT_IDLE) |-> !expire);

    p_mask_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq3_req && !irq_mask) |=> !irq3_req);

    p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq3_req && !irq3_ack) |=> irq3_req);

    p_irq_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq3_ack && !expire) |=> !irq3_req);

    p_read_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind prescaled_timer prescaled_timer_chk #(
    .SW_W   (SW_W),
    .IVT_W  (IVT_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wbe   (bus_wbe),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .irq_mask  (irq_mask),
    .irq3_ack  (irq3_ack),
    .irq3_req  (irq3_req),
    .tick      (tick_w),
    .sw_value  (sw_val),
    .expire    (ivt_expire),
    .ivt_state (ivt_st)
);

// File: tb/test_prescaled_timer.sv
`timescale 1ns/1ps
module test_prescaled_timer;
    localparam int P = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_addr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [1:0]  bus_wbe = '0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_rdata;
    logic        irq_mask = 1'b0;
    logic        irq3_ack = 1'b0;
    logic        irq3_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen_q = 1'b0;

    always #4 clk = ~clk;

    prescaled_timer #(.PRESCALE(P)) i_prescaled_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wbe   (bus_wbe),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .irq_mask  (irq_mask),
        .irq3_ack  (irq3_ack),
        .irq3_req  (irq3_req)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per completed read
    always @(posedge clk) rd_seen_q <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen_q) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected read", bus_rdata, 16'hxxxx);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic bus_write(input logic a, input logic [1:0] be, input logic [15:0] d);
        bus_addr = a; bus_wbe = be; bus_wdata = d;
        @(negedge clk);
        bus_wbe = 2'b00;
    endtask

    task automatic bus_read(input logic a, input logic [15:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse_ack();
        irq3_ack = 1'b1;
        @(negedge clk);
        irq3_ack = 1'b0;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        // R12 reset state
        check("R12 irq after reset", {15'd0, irq3_req}, 16'h0000);
        check("R12 rdata after reset", bus_rdata, 16'h0000);
        bus_read(1'b0, 16'h0000, "R12 elapsed after reset");
        bus_read(1'b1, 16'h0000, "R12 period after reset");

        // R4: first increment exactly P clocks after clear
        bus_write(1'b0, 2'b01, 16'hFFFF);
        wait_n(P - 1);
        bus_read(1'b0, 16'h0000, "R4 before first increment");
        bus_write(1'b0, 2'b11, 16'h5A5A);
        wait_n(P);
        bus_read(1'b0, 16'h0001, "R4 first increment");

        // R1 several ticks
        bus_write(1'b0, 2'b01, 16'h0000);
        wait_n(3 * P + 5);
        bus_read(1'b0, 16'h0003, "R1 three ticks");

        // R3: upper-lane-only write clears, data ignored
        bus_write(1'b0, 2'b01, 16'h0000);
        wait_n(5 * P);
        bus_write(1'b0, 2'b10, 16'h1234);
        wait_n(2);
        bus_read(1'b0, 16'h0000, "R3 lane-1 write clears");

        // R1/R2 wrap: 4095 then 0
        bus_write(1'b0, 2'b01, 16'h0000);
        wait_n(4095 * P);
        bus_read(1'b0, 16'h0FFF, "R2 max count with upper bits zero");
        wait_n(P - 1);
        bus_read(1'b0, 16'h0000, "R1 wrap to zero");

        // interval timer, N = 3 loaded one cycle after a clear (edge E0)
        irq_mask = 1'b1;
        bus_write(1'b0, 2'b01, 16'h0000);          // E0
        bus_write(1'b1, 2'b01, 16'hAB03);          // E0+1
        bus_read(1'b1, 16'h0003, "R5 period readback");   // E0+2
        wait_n(21);
        check("R6 no expiry before N*P", {15'd0, irq3_req}, 16'h0000);
        wait_n(1);
        check("R6 expiry at N*P", {15'd0, irq3_req}, 16'h0001);
        wait_n(5);
        check("R10 request held until ack", {15'd0, irq3_req}, 16'h0001);
        pulse_ack();                                // E0+30
        check("R10 ack clears request", {15'd0, irq3_req}, 16'h0000);
        wait_n(17);
        check("R7 no early reload expiry", {15'd0, irq3_req}, 16'h0000);
        wait_n(1);
        check("R7 periodic expiry", {15'd0, irq3_req}, 16'h0001);
        pulse_ack();                                // E0+49
        irq_mask = 1'b0;
        wait_n(31);                                 // past E0+72 masked expiry
        check("R9 masked expiry raises nothing", {15'd0, irq3_req}, 16'h0000);
        irq_mask = 1'b1;
        wait_n(15);
        check("R9 no request before next expiry", {15'd0, irq3_req}, 16'h0000);
        wait_n(1);
        check("R9 unmasked expiry raises request", {15'd0, irq3_req}, 16'h0001);
        pulse_ack();                                // E0+97

        // R8: zero stops the timer
        bus_write(1'b1, 2'b01, 16'h0000);          // E0+98
        bus_read(1'b1, 16'h0000, "R8 zero period readback");
        wait_n(30);
        check("R8 no expiry after zero load", {15'd0, irq3_req}, 16'h0000);

        // R5: lane-1-only write does not touch period
        bus_write(1'b1, 2'b10, 16'hFFFF);
        bus_read(1'b1, 16'h0000, "R5 lane-1 write ignored");
        bus_write(1'b1, 2'b11, 16'hFF07);
        bus_read(1'b1, 16'h0007, "R5 lane-0 write loads low byte");

        wait_n(3);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R11 pending reads actual %0d expected 0", exp_q.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end
endmodule